// File: doc/BRIEF.md
# DMA Channel Request Recognizer

This block sits between a peripheral's service-request pin and one DMA channel's sequencer. It decides when the channel has a request waiting for service. It also decides, at the end of each operand transfer, whether a further request may be served while the channel still owns the bus. The request pin is first passed through a multi-stage synchronizer. After that it is read in one of two ways, chosen per channel at run time.

In level mode, the peripheral holds the pin active for as long as it wants service. A request chains onto the current bus tenure only if it is active when the acknowledge is seen and stays active up to the data-transfer-complete clock. In pulse mode, the peripheral sends a short pulse for each operand. A pulse counts only if it is seen active on a programmable number of consecutive clock edges. Pulses are dropped while a request waits for its acknowledge. A pulse arriving between acknowledge and transfer-complete is queued and served on the same tenure. In level mode, the block also handles a request withdrawn early: before grant it is simply dropped, and after grant but before the first bus cycle starts it is cancelled.

Top module: `dma_req_recognizer`

## Requirements
- R1: During and right after reset, `pend_o`, `cont_o` and `cancel_o` are all low.
- R2: A request change reaches the decision logic only after `SYNC_STAGES` clock edges. In level mode with default parameters, `pend_o` rises on the third rising edge after the pin goes active and not before.
- R3: With `mode_i` = 0 (level mode) and the channel idle, an active request pin (`req_n_i` low) sets `pend_o`. It stays set until the first bus cycle starts (`first_started_i`) or the request is withdrawn.
- R4: In level mode, suppose the request is active when `ack_i` is seen and stays active through the edge that samples `dtc_i`. Then `cont_o` pulses for one cycle right after that edge, and `pend_o` is high in that same cycle.
- R5: In level mode, if the request goes inactive at any point between acknowledge and `dtc_i`, no continuation is given at `dtc_i`. `cont_o` stays low and `pend_o` goes low.
- R6: In level mode, suppose a pending request is withdrawn while `bus_grant_i` is high and before `first_started_i`. Then `cancel_o` pulses for one cycle and `pend_o` falls in that same cycle.
- R7: In level mode, a pending request withdrawn while `bus_grant_i` is low clears `pend_o` without any `cancel_o` pulse.
- R8: In level mode, a request withdrawn after `first_started_i` has been seen never produces `cancel_o`. The transfer stays open until `dtc_i`.
- R9: With `mode_i` = 1 (pulse mode), a pulse is valid only if the synchronized request is active on `STEAL_HOLD` consecutive edges. With the default of 2, a one-cycle pulse never sets `pend_o`, and pulses of two or more cycles set it exactly once.
- R10: In pulse mode, valid pulses that arrive while a request is pending, or during a transfer before `ack_i` is seen, are dropped. The transfer then ends at `dtc_i` with `cont_o` low and `pend_o` low.
- R11: In pulse mode, a valid pulse that arrives after `ack_i` and up to `dtc_i` makes `cont_o` pulse right after `dtc_i`, with `pend_o` high.
- R12: `cont_o` and `cancel_o` are never high in the same cycle. `cont_o` is high only in the cycle after `dtc_i` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 1 | Peripheral request pin, asynchronous; active low by default |
| mode_i | input | 1 | 0 = level mode, 1 = pulse mode |
| bus_grant_i | input | 1 | Bus ownership has been granted to this channel |
| first_started_i | input | 1 | First bus cycle of the operand transfer has reached its start state |
| ack_i | input | 1 | Channel acknowledge to the peripheral is active |
| dtc_i | input | 1 | Data-transfer-complete clock of the current operand |
| pend_o | output | 1 | A recognized request is waiting for its transfer to start |
| cont_o | output | 1 | One-cycle pulse: keep the bus and serve the next request |
| cancel_o | output | 1 | One-cycle pulse: abandon the transfer before strobes are driven |

## Verification
The checker tests these rules on every cycle:
- A continuation follows a sampled transfer-complete and is never given alone.
- A continuation and a cancel never coincide.
- A cancel occurs only while granted and before the transfer started, lasts one cycle, and leaves nothing pending.

Only the bench scenarios can show which requests are dropped and which are honoured, because that depends on when the pin moves relative to acknowledge and transfer-complete. These cases are:
- the synchronizer latency;
- the minimum pulse width swept over several lengths;
- pulses dropped before acknowledge;
- level requests released just before transfer-complete.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;

   typedef enum logic {
      RQ_MODE_LEVEL = 1'b0,
      RQ_MODE_PULSE = 1'b1
   } rq_mode_e;

   typedef enum logic [1:0] {
      RQ_IDLE = 2'd0,
      RQ_PEND = 2'd1,
      RQ_XFER = 2'd2
   } rq_state_e;

endpackage

// File: rtl/dma_rr_sync.sv
module dma_rr_sync #(
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic act_o
);

   localparam int unsigned LAST = STAGES - 1;

   logic             pin_act;
   logic [LAST:0]    chain_q;

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign pin_act = ~pin_i;
      end else begin : g_pass
         assign pin_act = pin_i;
      end
   endgenerate

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= pin_act;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[LAST-1:0], pin_act};
         end
      end
   endgenerate

   assign act_o = chain_q[LAST];

endmodule

// File: rtl/dma_rr_pulse.sv
module dma_rr_pulse #(
   parameter int unsigned HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   output logic evt_o
);

   generate
      if (HOLD == 1) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= act_i;
         end
         assign evt_o = act_i & ~prev_q;
      end else begin : g_filter
         localparam int unsigned TOP = HOLD - 1;
         logic [TOP:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= '0;
            else        hist_q <= {hist_q[TOP-1:0], act_i};
         end
         assign evt_o = act_i & (&hist_q[TOP-1:0]) & ~hist_q[TOP];
      end
   endgenerate

endmodule

// File: rtl/dma_rr_fsm.sv
module dma_rr_fsm
   import dma_rr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic lvl_i,
   input  logic evt_i,
   input  logic bus_grant_i,
   input  logic first_started_i,
   input  logic ack_i,
   input  logic dtc_i,
   output logic pend_o,
   output logic cont_o,
   output logic cancel_o
);

   rq_state_e st_q, st_d;
   logic      hold_q, hold_d;
   logic      ackd_q, ackd_d;
   logic      queue_q, queue_d;
   logic      cont_q, cont_d;
   logic      cancel_q, cancel_d;
   logic      is_pulse;
   logic      chain;

   assign is_pulse = (rq_mode_e'(mode_i) == RQ_MODE_PULSE);

   always_comb begin
      st_d     = st_q;
      hold_d   = hold_q;
      ackd_d   = ackd_q;
      queue_d  = queue_q;
      cont_d   = 1'b0;
      cancel_d = 1'b0;
      chain    = 1'b0;
      unique case (st_q)
         RQ_IDLE: begin
            if (is_pulse ? evt_i : lvl_i) st_d = RQ_PEND;
         end
         RQ_PEND: begin
            if (first_started_i) begin
               st_d    = RQ_XFER;
               hold_d  = 1'b0;
               ackd_d  = 1'b0;
               queue_d = 1'b0;
            end else if (!is_pulse && !lvl_i) begin
               st_d     = RQ_IDLE;
               cancel_d = bus_grant_i;
            end
         end
         RQ_XFER: begin
            if (!lvl_i)     hold_d = 1'b0;
            else if (ack_i) hold_d = 1'b1;
            if (ack_i) ackd_d = 1'b1;
            if (evt_i && (ack_i || ackd_q)) queue_d = 1'b1;
            if (dtc_i) begin
               chain = is_pulse ? queue_d : hold_d;
               st_d  = chain ? RQ_PEND : RQ_IDLE;
               cont_d = chain;
            end
         end
         default: st_d = RQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= RQ_IDLE;
         hold_q   <= 1'b0;
         ackd_q   <= 1'b0;
         queue_q  <= 1'b0;
         cont_q   <= 1'b0;
         cancel_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         hold_q   <= hold_d;
         ackd_q   <= ackd_d;
         queue_q  <= queue_d;
         cont_q   <= cont_d;
         cancel_q <= cancel_d;
      end
   end

   assign pend_o   = (st_q == RQ_PEND);
   assign cont_o   = cont_q;
   assign cancel_o = cancel_q;

endmodule

// File: rtl/dma_req_recognizer.sv
module dma_req_recognizer #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STEAL_HOLD  = 2,
   parameter bit          REQ_LOW     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n_i,
   input  logic mode_i,
   input  logic bus_grant_i,
   input  logic first_started_i,
   input  logic ack_i,
   input  logic dtc_i,
   output logic pend_o,
   output logic cont_o,
   output logic cancel_o
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (STEAL_HOLD < 1) begin : g_bad_hold
         $error("STEAL_HOLD must be at least 1");
      end
   endgenerate

   logic lvl;
   logic evt;

   dma_rr_sync #(
      .STAGES     (SYNC_STAGES),
      .ACTIVE_LOW (REQ_LOW)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (req_n_i),
      .act_o (lvl)
   );

   dma_rr_pulse #(
      .HOLD (STEAL_HOLD)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .act_i (lvl),
      .evt_o (evt)
   );

   dma_rr_fsm u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode_i          (mode_i),
      .lvl_i           (lvl),
      .evt_i           (evt),
      .bus_grant_i     (bus_grant_i),
      .first_started_i (first_started_i),
      .ack_i           (ack_i),
      .dtc_i           (dtc_i),
      .pend_o          (pend_o),
      .cont_o          (cont_o),
      .cancel_o        (cancel_o)
   );

endmodule

// File: rtl/dma_rr_chk.sv
module dma_rr_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_grant_i,
   input logic first_started_i,
   input logic dtc_i,
   input logic pend_o,
   input logic cont_o,
   input logic cancel_o
);

   // R12
   cont_after_dtc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cont_o |-> $past(dtc_i));

   // R4
   cont_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cont_o |-> pend_o);

   // R12
   cont_cancel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cont_o && cancel_o));

   // R6
   cancel_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_o |-> ($past(bus_grant_i) && !$past(first_started_i)));

   // R6
   cancel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_o |=> !cancel_o);

   // R6
   cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_o |-> !pend_o);

endmodule

bind dma_req_recognizer dma_rr_chk u_rr_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .bus_grant_i     (bus_grant_i),
   .first_started_i (first_started_i),
   .dtc_i           (dtc_i),
   .pend_o          (pend_o),
   .cont_o          (cont_o),
   .cancel_o        (cancel_o)
);

// File: tb/tb_dma_req_recognizer.sv
module tb_dma_req_recognizer;

   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_n = 1'b1;
   logic mode = 1'b0;
   logic grant = 1'b0;
   logic fs = 1'b0;
   logic ack = 1'b0;
   logic dtc = 1'b0;
   logic pend, cont, cancel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   dma_req_recognizer dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_n_i         (req_n),
      .mode_i          (mode),
      .bus_grant_i     (grant),
      .first_started_i (fs),
      .ack_i           (ack),
      .dtc_i           (dtc),
      .pend_o          (pend),
      .cont_o          (cont),
      .cancel_o        (cancel)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic m);
      rst_n = 1'b0; req_n = 1'b1; grant = 1'b0; fs = 1'b0; ack = 1'b0; dtc = 1'b0;
      mode = m;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic pulse_fs();
      fs = 1'b1; step(1); fs = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1; step(1); ack = 1'b0;
   endtask

   initial begin
      step(1);
      // R1 reset values
      chk("R1", "pend", pend, 1'b0);
      chk("R1", "cont", cont, 1'b0);
      chk("R1", "cancel", cancel, 1'b0);
      do_reset(1'b0);
      chk("R1", "pend after release", pend, 1'b0);

      // R2 / R3: level request latency
      req_n = 1'b0; grant = 1'b1;
      step(2);
      chk("R2", "pend before sync", pend, 1'b0);
      step(1);
      chk("R3", "pend level", pend, 1'b1);

      // R4: chained burst
      pulse_fs();
      chk("R3", "pend cleared at start", pend, 1'b0);
      pulse_ack();
      dtc = 1'b1; step(1); dtc = 1'b0;
      chk("R4", "cont", cont, 1'b1);
      chk("R4", "pend with cont", pend, 1'b1);
      step(1);
      chk("R4", "cont one cycle", cont, 1'b0);

      // R5: released before DTC
      pulse_fs();
      pulse_ack();
      req_n = 1'b1; step(3);
      dtc = 1'b1; step(1); dtc = 1'b0;
      chk("R5", "cont", cont, 1'b0);
      chk("R5", "pend", pend, 1'b0);

      // R6: withdrawn after grant
      req_n = 1'b0; step(3);
      chk("R3", "pend again", pend, 1'b1);
      req_n = 1'b1; step(3);
      chk("R6", "cancel", cancel, 1'b1);
      chk("R6", "pend", pend, 1'b0);
      step(1);
      chk("R6", "cancel one cycle", cancel, 1'b0);

      // R7: withdrawn before grant
      grant = 1'b0;
      req_n = 1'b0; step(3);
      chk("R7", "pend set", pend, 1'b1);
      req_n = 1'b1; step(3);
      chk("R7", "cancel", cancel, 1'b0);
      chk("R7", "pend", pend, 1'b0);

      // R8: withdrawn after start
      grant = 1'b1;
      req_n = 1'b0; step(3);
      pulse_fs();
      req_n = 1'b1; step(3);
      chk("R8", "cancel", cancel, 1'b0);
      chk("R8", "pend", pend, 1'b0);
      dtc = 1'b1; step(1); dtc = 1'b0;
      chk("R8", "cancel at dtc", cancel, 1'b0);
      chk("R8", "cont at dtc", cont, 1'b0);

      // R9: pulse width sweep, valid iff width >= 2
      for (int len = 1; len <= 4; len++) begin
         do_reset(1'b1);
         req_n = 1'b0; step(len); req_n = 1'b1;
         step(5);
         chk("R9", $sformatf("pend width %0d", len), pend, (len >= 2) ? 1'b1 : 1'b0);
      end

      // R10: pulses while pending and before ack are dropped
      req_n = 1'b0; step(3); req_n = 1'b1; step(5);
      chk("R10", "still pending", pend, 1'b1);
      pulse_fs();
      req_n = 1'b0; step(3); req_n = 1'b1; step(3);
      pulse_ack();
      step(2);
      dtc = 1'b1; step(1); dtc = 1'b0;
      chk("R10", "cont", cont, 1'b0);
      chk("R10", "pend", pend, 1'b0);

      // R11: pulse after ack chains
      req_n = 1'b0; step(3); req_n = 1'b1; step(5);
      chk("R11", "pend setup", pend, 1'b1);
      pulse_fs();
      pulse_ack();
      req_n = 1'b0; step(3); req_n = 1'b1; step(3);
      dtc = 1'b1; step(1); dtc = 1'b0;
      chk("R11", "cont", cont, 1'b1);
      chk("R11", "pend", pend, 1'b1);
      chk("R12", "no cancel with cont", cancel, 1'b0);
      step(1);
      chk("R12", "cont only after dtc", cont, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule